// File: doc/BRIEF.md
# T3 Frame Overhead Error Injector

This block sits in the serial transmit path of a T3/E3 framer. Its job is to corrupt selected overhead bits on purpose, so that the far end's error counters and alarms can be tested. The framer supplies the serial data, one bit per clock. With each bit it supplies strobes that say which overhead slot the bit occupies: the two parity bits, the three C-bit parity bits, framing bits, multiframe alignment bits, the start of an M-subframe and the start of a multiframe. The block then returns the same stream one clock later, with the requested overhead bits inverted.

The requests arrive as an eight-bit control word. In automatic mode, each error type is a one-shot. A rising edge on its arm bit schedules one error, and that error lands on the next matching overhead slot or group. Parity-bit and C-bit parity errors always hit every bit of the group within one multiframe. Framing errors hit one bit, a whole subframe's F bits or a whole multiframe's M bits, as chosen by a two-bit type select. In manual mode the arm bits become enables. Every toggle of a strobe input then fires one error of each enabled type. The operating mode gates each type.

Top module: `t3_ovh_err_inject`

## Requirements
- R1: Each output bit equals the input bit of one clock earlier. A bit is inverted only when it is in a targeted overhead slot.
- R2: In automatic mode and T3 mode, a 0-to-1 change of control bit 2 inverts both parity-bit slots of the next multiframe. A request made after a multiframe has started waits for the start of the following one.
- R3: In automatic mode, T3 mode and with C-bit parity enabled, a 0-to-1 change of control bit 3 inverts all three C-bit parity slots of the next multiframe.
- R4: Parity-bit and C-bit parity requests never alter data in E3 mode. C-bit parity requests never alter data while C-bit parity is disabled.
- R5: Each request is a one-shot. An arm bit that stays high schedules nothing further. The bit must fall and rise again before another error of that type is scheduled.
- R6: A 0-to-1 change of control bit 4 schedules a framing error whose type is read from control bits 6:5. Type 00 inverts the next F-bit slot only. Type 01 inverts the next M-bit slot only.
- R7: Type 10 inverts all F-bit slots of the next M-subframe. Type 11 inverts all three M-bit slots of the next multiframe.
- R8: When control bit 7 (manual) is high, rising edges of the arm bits schedule nothing. Each change of the manual strobe, in either direction, schedules one error of every type whose control bit is high, and none of any type whose bit is low.
- R9: Control bits 1:0 belong to line-code error types that are handled elsewhere. Setting them has no effect on the output.
- R10: While reset is asserted the output is 0, and after reset no error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e3_mode_i | input | 1 | 1 = E3 operation, 0 = T3 |
| cbit_en_i | input | 1 | 1 = C-bit parity format in use |
| ctrl_i | input | 8 | Error control word (bit 2 P, 3 CP, 4 frame, 6:5 frame type, 7 manual) |
| manual_stb_i | input | 1 | Manual error strobe; every change fires in manual mode |
| mf_start_i | input | 1 | Current bit is the first bit of a multiframe |
| sub_start_i | input | 1 | Current bit is the first bit of an M-subframe |
| p_slot_i | input | 1 | Current bit is a parity (P) bit |
| cp_slot_i | input | 1 | Current bit is a C-bit parity bit |
| f_slot_i | input | 1 | Current bit is a framing (F) bit |
| m_slot_i | input | 1 | Current bit is a multiframe alignment (M) bit |
| data_i | input | 1 | Serial transmit data in |
| data_o | output | 1 | Serial transmit data out, one clock later |

## Verification
Each output bit is due one clock after its input bit, so the bench reads the output just after the next rising edge and compares it with the bit it drove. An arm or strobe change is taken in the cycle it is driven. Its effect is due at a multiframe boundary for the parity groups and the M-bit window, at a subframe boundary for the F-bit window, or at the next matching slot for the single-bit types. The bench therefore scores each scenario by whole frames: the frame of the request must show no group error, the frame after must show exactly the full group, and the single and windowed framing errors must total exactly one group across the two frames. Requests are always placed after the first bit of a frame, so that no result depends on same-cycle ordering at the frame boundary.

// File: rtl/t3oei_pkg.sv
package t3oei_pkg;
    localparam int CTRL_W     = 8;
    localparam int BIT_P      = 2;
    localparam int BIT_CP     = 3;
    localparam int BIT_F      = 4;
    localparam int BIT_TYP_LO = 5;
    localparam int TYP_W      = 2;
    localparam int BIT_MAN    = 7;

    localparam int NUM_TRIG   = 3;
    localparam int TRIG_P     = 0;
    localparam int TRIG_CP    = 1;
    localparam int TRIG_F     = 2;
    localparam int NUM_GROUP  = 2;

    typedef enum logic [TYP_W-1:0] {
        FE_ONE_F = 2'b00,
        FE_ONE_M = 2'b01,
        FE_SUB_F = 2'b10,
        FE_MF_M  = 2'b11
    } fe_type_e;

    function automatic int arm_bit(input int idx);
        case (idx)
            TRIG_P:  return BIT_P;
            TRIG_CP: return BIT_CP;
            default: return BIT_F;
        endcase
    endfunction
endpackage

// File: rtl/oei_trig_gen.sv
module oei_trig_gen
    import t3oei_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic                manual_stb_i,
    input  logic                e3_mode_i,
    input  logic                cbit_en_i,
    output logic [NUM_TRIG-1:0] trig_o
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] arm;
        logic                stb;
    } trig_st_t;

    trig_st_t            st_d, st_q;
    logic [NUM_TRIG-1:0] arm_now;
    logic [NUM_TRIG-1:0] allow;
    logic [NUM_TRIG-1:0] hit;
    logic                toggled;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_arm
        assign arm_now[g] = ctrl_i[arm_bit(g)];
    end

    always_comb begin
        st_d.arm = arm_now;
        st_d.stb = manual_stb_i;
        toggled  = manual_stb_i ^ st_q.stb;

        allow          = '1;
        allow[TRIG_P]  = ~e3_mode_i;
        allow[TRIG_CP] = ~e3_mode_i & cbit_en_i;

        if (ctrl_i[BIT_MAN]) begin
            hit = {NUM_TRIG{toggled}} & arm_now;
        end else begin
            hit = arm_now & ~st_q.arm;
        end
        trig_o = hit & allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_manual_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[BIT_MAN] && (manual_stb_i == st_q.stb)) |-> (trig_o == '0));

    p_held_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i[BIT_MAN] && st_q.arm[TRIG_P]) |-> !trig_o[TRIG_P]);
endmodule

// File: rtl/oei_group_inj.sv
module oei_group_inj (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic frame_start_i,
    input  logic slot_i,
    input  logic allow_i,
    output logic flip_o
);
    typedef struct packed {
        logic pend;
        logic act;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.act  = st_q.pend;
            st_d.pend = 1'b0;
        end
        if (trig_i) begin
            st_d.pend = 1'b1;
        end
        flip_o = st_q.act & slot_i & allow_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_act_at_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(frame_start_i));

    p_act_whole_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !frame_start_i) |=> st_q.act);
endmodule

// File: rtl/oei_fbit_inj.sv
module oei_fbit_inj
    import t3oei_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [TYP_W-1:0] typ_i,
    input  logic             sub_start_i,
    input  logic             mf_start_i,
    input  logic             f_slot_i,
    input  logic             m_slot_i,
    output logic             flip_o
);
    typedef struct packed {
        logic     pend;
        fe_type_e typ;
        logic     act;
        logic     act_m;
    } fb_st_t;

    fb_st_t st_d, st_q;
    logic   win_end;

    always_comb begin
        st_d    = st_q;
        flip_o  = 1'b0;
        win_end = st_q.act_m ? mf_start_i : sub_start_i;

        if (st_q.act) begin
            if (win_end) begin
                st_d.act = 1'b0;
            end else begin
                flip_o = st_q.act_m ? m_slot_i : f_slot_i;
            end
        end

        if (st_q.pend) begin
            case (st_q.typ)
                FE_ONE_F: if (f_slot_i) begin
                    flip_o    = 1'b1;
                    st_d.pend = 1'b0;
                end
                FE_ONE_M: if (m_slot_i) begin
                    flip_o    = 1'b1;
                    st_d.pend = 1'b0;
                end
                FE_SUB_F: if (sub_start_i) begin
                    st_d.act   = 1'b1;
                    st_d.act_m = 1'b0;
                    st_d.pend  = 1'b0;
                end
                default: if (mf_start_i) begin
                    st_d.act   = 1'b1;
                    st_d.act_m = 1'b1;
                    st_d.pend  = 1'b0;
                end
            endcase
        end

        if (trig_i) begin
            st_d.pend = 1'b1;
            st_d.typ  = fe_type_e'(typ_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_single_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.typ == FE_ONE_F && f_slot_i && !trig_i) |=> !st_q.pend);

    p_flip_on_fm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flip_o |-> (f_slot_i || m_slot_i));

    p_window_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(sub_start_i || mf_start_i));
endmodule

// File: rtl/t3_ovh_err_inject.sv
module t3_ovh_err_inject
    import t3oei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e3_mode_i,
    input  logic              cbit_en_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              manual_stb_i,
    input  logic              mf_start_i,
    input  logic              sub_start_i,
    input  logic              p_slot_i,
    input  logic              cp_slot_i,
    input  logic              f_slot_i,
    input  logic              m_slot_i,
    input  logic              data_i,
    output logic              data_o
);
    typedef struct packed {
        logic data;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic [NUM_TRIG-1:0]  trig;
    logic [NUM_GROUP-1:0] grp_trig, grp_slot, grp_allow, grp_flip;
    logic                 fb_flip;
    logic                 flip;

    oei_trig_gen u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl_i),
        .manual_stb_i(manual_stb_i),
        .e3_mode_i   (e3_mode_i),
        .cbit_en_i   (cbit_en_i),
        .trig_o      (trig)
    );

    assign grp_trig  = {trig[TRIG_CP], trig[TRIG_P]};
    assign grp_slot  = {cp_slot_i, p_slot_i};
    assign grp_allow = {~e3_mode_i & cbit_en_i, ~e3_mode_i};

    for (genvar g = 0; g < NUM_GROUP; g++) begin : g_grp
        oei_group_inj u_grp (
            .clk          (clk),
            .rst_n        (rst_n),
            .trig_i       (grp_trig[g]),
            .frame_start_i(mf_start_i),
            .slot_i       (grp_slot[g]),
            .allow_i      (grp_allow[g]),
            .flip_o       (grp_flip[g])
        );
    end

    oei_fbit_inj u_fbit (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig[TRIG_F]),
        .typ_i      (ctrl_i[BIT_TYP_LO +: TYP_W]),
        .sub_start_i(sub_start_i),
        .mf_start_i (mf_start_i),
        .f_slot_i   (f_slot_i),
        .m_slot_i   (m_slot_i),
        .flip_o     (fb_flip)
    );

    always_comb begin
        flip      = (|grp_flip) | fb_flip;
        st_d.data = data_i ^ flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_slot_i || cp_slot_i || f_slot_i || m_slot_i) |=> (data_o == $past(data_i)));

    p_e3_no_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_mode_i && (p_slot_i || cp_slot_i) && !f_slot_i && !m_slot_i)
            |=> (data_o == $past(data_i)));

    p_cp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cbit_en_i && cp_slot_i && !p_slot_i && !f_slot_i && !m_slot_i)
            |=> (data_o == $past(data_i)));

    p_reset_low_r10: assert property (@(posedge clk) !rst_n |-> (data_o == 1'b0));
endmodule

// File: tb/t3_ovh_err_inject_bench.sv
`timescale 1ns/1ps
module t3_ovh_err_inject_bench;
    localparam int SUB_LEN = 16;
    localparam int NSUB    = 7;
    localparam int FR_LEN  = SUB_LEN * NSUB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e3_mode_i = 1'b0, cbit_en_i = 1'b1;
    logic [7:0] ctrl_i = 8'h00;
    logic       manual_stb_i = 1'b0;
    logic       mf_start_i = 1'b0, sub_start_i = 1'b0;
    logic       p_slot_i = 1'b0, cp_slot_i = 1'b0, f_slot_i = 1'b0, m_slot_i = 1'b0;
    logic       data_i = 1'b0;
    logic       data_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int pos   = 0;
    int fc_p, fc_cp, fc_f, fc_m, fc_oth, fsub_max;
    int fsub [NSUB];

    always #2.5 clk = ~clk;

    t3_ovh_err_inject u_t3_ovh_err_inject (
        .clk(clk), .rst_n(rst_n), .e3_mode_i(e3_mode_i), .cbit_en_i(cbit_en_i),
        .ctrl_i(ctrl_i), .manual_stb_i(manual_stb_i), .mf_start_i(mf_start_i),
        .sub_start_i(sub_start_i), .p_slot_i(p_slot_i), .cp_slot_i(cp_slot_i),
        .f_slot_i(f_slot_i), .m_slot_i(m_slot_i), .data_i(data_i), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_p(input int s, input int o);  return o == 0 && (s == 2 || s == 3); endfunction
    function automatic bit is_m(input int s, input int o);  return o == 0 && s >= 4; endfunction
    function automatic bit is_f(input int o);               return (o % 2 == 0) && ((o / 2) % 2 == 1); endfunction
    function automatic bit is_cp(input int s, input int o);
        return s == 2 && (o % 2 == 0) && (o / 2 == 2 || o / 2 == 4 || o / 2 == 6);
    endfunction

    task automatic tick();
        int  s, o;
        bit  sent, fl;
        s = pos / SUB_LEN;
        o = pos % SUB_LEN;
        @(negedge clk);
        sent        = 1'($urandom);
        data_i      = sent;
        mf_start_i  = (pos == 0);
        sub_start_i = (o == 0);
        p_slot_i    = is_p(s, o);
        cp_slot_i   = is_cp(s, o);
        f_slot_i    = is_f(o);
        m_slot_i    = is_m(s, o);
        @(posedge clk);
        #1;
        fl = data_o ^ sent;
        if (fl) begin
            if (is_p(s, o))       fc_p++;
            else if (is_cp(s, o)) fc_cp++;
            else if (is_f(o))     begin fc_f++; fsub[s]++; end
            else if (is_m(s, o))  fc_m++;
            else                  fc_oth++;
        end
        pos = (pos + 1) % FR_LEN;
    endtask

    task automatic run_frame(input int at, input logic [7:0] nc, input bit tog);
        fc_p = 0; fc_cp = 0; fc_f = 0; fc_m = 0; fc_oth = 0; fsub_max = 0;
        foreach (fsub[i]) fsub[i] = 0;
        for (int i = 0; i < FR_LEN; i++) begin
            if (i == at) begin
                ctrl_i = nc;
                if (tog) manual_stb_i = ~manual_stb_i;
            end
            tick();
        end
        foreach (fsub[i]) if (fsub[i] > fsub_max) fsub_max = fsub[i];
    endtask

    function automatic int rpos();
        return int'($urandom_range(1, FR_LEN - 1));
    endfunction

    task automatic expect_frame(input string req, input int ep, input int ecp,
                                input int ef, input int em);
        chk(fc_p == ep,    req, "P flips",     fc_p, ep);
        chk(fc_cp == ecp,  req, "CP flips",    fc_cp, ecp);
        chk(fc_f == ef,    req, "F flips",     fc_f, ef);
        chk(fc_m == em,    req, "M flips",     fc_m, em);
        chk(fc_oth == 0,   "R1", "other flips", fc_oth, 0);
    endtask

    // Arms one automatic error of the given kind and scores the arming frame and the next one.
    task automatic arm_check(input int kind);
        logic [7:0] nc;
        int a_f, a_m, a_max;
        run_frame(rpos(), 8'h00, 0);
        case (kind)
            0: nc = 8'h04;
            1: nc = 8'h08;
            default: nc = 8'h10 | 8'((kind - 2) << 5);
        endcase
        run_frame(rpos(), nc, 0);
        chk(fc_p == 0 && fc_cp == 0, "R2", "group flips in arming frame", fc_p + fc_cp, 0);
        chk(fc_oth == 0, "R1", "other flips", fc_oth, 0);
        a_f = fc_f; a_m = fc_m; a_max = fsub_max;
        run_frame(-1, 8'h00, 0);
        case (kind)
            0: expect_frame("R2", 2, 0, 0, 0);
            1: expect_frame("R3", 0, 3, 0, 0);
            2: begin
                chk(a_f + fc_f == 1, "R6", "single F total", a_f + fc_f, 1);
                chk(a_m + fc_m == 0, "R6", "M with F type", a_m + fc_m, 0);
            end
            3: begin
                chk(a_m + fc_m == 1, "R6", "single M total", a_m + fc_m, 1);
                chk(a_f + fc_f == 0, "R6", "F with M type", a_f + fc_f, 0);
            end
            4: begin
                chk(a_f + fc_f == 4, "R7", "subframe F total", a_f + fc_f, 4);
                chk(a_max == 4 || fsub_max == 4, "R7", "F in one subframe",
                    (a_max > fsub_max) ? a_max : fsub_max, 4);
            end
            default: begin
                chk(a_m == 0, "R7", "M in arming frame", a_m, 0);
                chk(fc_m == 3, "R7", "M in next frame", fc_m, 3);
            end
        endcase
        if (kind <= 1) begin
            run_frame(-1, 8'h00, 0);
            chk(fc_p + fc_cp == 0, "R5", "flips with arm held", fc_p + fc_cp, 0);
        end
        ctrl_i = 8'h00;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        data_i = 1'b1; p_slot_i = 1'b1; f_slot_i = 1'b1; ctrl_i = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        chk(data_o == 1'b0, "R10", "data_o in reset", data_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        pos = 0;

        // R1 / R10: idle frames pass through untouched
        run_frame(-1, 8'h00, 0);
        expect_frame("R10", 0, 0, 0, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R1", 0, 0, 0, 0);

        // R2 and R5 directed: arm held, then clear and re-arm
        arm_check(0);
        run_frame(rpos(), 8'h04, 0);
        run_frame(rpos(), 8'h00, 0);
        run_frame(rpos(), 8'h04, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R5", 2, 0, 0, 0);
        ctrl_i = 8'h00;

        // R3 directed, then every framing type
        arm_check(1);
        for (int k = 2; k < 6; k++) arm_check(k);

        // R4: C-bit parity disabled
        cbit_en_i = 1'b0;
        run_frame(rpos(), 8'h08, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R4", 0, 0, 0, 0);
        // R4: E3 mode blocks P and CP
        cbit_en_i = 1'b1; e3_mode_i = 1'b1;
        run_frame(rpos(), 8'h00, 0);
        run_frame(rpos(), 8'h0C, 0);
        chk(fc_p + fc_cp == 0, "R4", "E3 arming frame", fc_p + fc_cp, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R4", 0, 0, 0, 0);
        e3_mode_i = 1'b0;
        run_frame(rpos(), 8'h00, 0);

        // R9: low two bits do nothing
        run_frame(rpos(), 8'h03, 0);
        expect_frame("R9", 0, 0, 0, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R9", 0, 0, 0, 0);

        // R8: manual mode, edges ignored, toggles fire
        run_frame(rpos(), 8'h8C, 0);
        chk(fc_p + fc_cp == 0, "R8", "manual edge ignored", fc_p + fc_cp, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R8", 0, 0, 0, 0);
        run_frame(rpos(), 8'h8C, 1);
        chk(fc_p + fc_cp == 0, "R8", "toggle frame", fc_p + fc_cp, 0);
        run_frame(rpos(), 8'h8C, 1);
        expect_frame("R8", 2, 3, 0, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R8", 2, 3, 0, 0);
        run_frame(rpos(), 8'h84, 1);
        run_frame(-1, 8'h00, 0);
        expect_frame("R8", 2, 0, 0, 0);
        run_frame(-1, 8'h00, 0);
        expect_frame("R8", 0, 0, 0, 0);
        ctrl_i = 8'h00;
        run_frame(rpos(), 8'h00, 0);

        // constrained random repeats of the automatic types
        for (int it = 0; it < 10; it++) arm_check(int'($urandom_range(0, 5)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule